// File: doc/BRIEF.md
# Page Permission and Fault Encoder

This block judges one leaf page-table entry against a single memory access. It takes the low attribute byte of the entry and the access kind (read, write, read-modify-write, execute). It also takes the effective privilege (user or supervisor) and two mode flags: one lets executable pages be read, the other lets the supervisor reach user pages. From these it decides whether the access is permitted, and classifies the byte as an invalid entry and/or a pointer to a further table level.

The block also works out whether the accessed and dirty bits must be set before the access may complete, and gives the attribute byte that would be written back. Whether that write is performed is decided outside this block. A separate path turns an internal failure code, together with the access kind, into an architectural exception cause number. The walker's sequencer uses this to report a fault.

Everything is combinational. There is no clock, no reset and no storage, so each output follows its inputs within the same cycle.

Top module: `pgperm_top`

## Requirements
- R1: `invalid_o` is 1 exactly when the valid bit (attribute bit 0) is clear, or when the write bit (bit 2) is set while the read bit (bit 1) is clear.
- R2: `pointer_o` is 1 exactly when the read (bit 1), write (bit 2) and execute (bit 3) bits are all clear. Such a byte never yields `permit_o` = 1.
- R3: With `priv_user_i` = 1, `permit_o` requires the user bit (bit 4) set. Access kind encoding is 0 read, 1 write, 2 read-modify-write, 3 execute. Read needs the read condition, write needs bit 2, read-modify-write needs both bit 2 and the read condition, and execute needs bit 3.
- R4: With `priv_user_i` = 0, a read, write or read-modify-write access to a page with bit 4 set is permitted only when `sup_user_ok_i` = 1. Pages with bit 4 clear follow the same per-kind rules as R3.
- R5: With `priv_user_i` = 0, an execute access is permitted exactly when bit 4 is clear and bit 3 is set, whatever `sup_user_ok_i` holds.
- R6: The read condition is bit 1 set, or bit 3 set with `exec_readable_i` = 1. `exec_readable_i` has no effect on write or execute access.
- R7: `upd_need_o` is 1 when the accessed bit (bit 6) is clear, or when the access is a write or read-modify-write and the dirty bit (bit 7) is clear. `attr_new_o` then has bit 6 set, and bit 7 set in the second case. When `upd_need_o` is 0, `attr_new_o` equals `attr_i`.
- R8: `attr_new_o` bits 5 down to 0 always equal the same bits of `attr_i`.
- R9: `cause_o` maps `fail_code_i` and the access kind to an exception cause. Failure codes are 0 access error, 1 invalid entry, 2 no permission, 3 misaligned superpage, 4 update needed but disabled. Code 0 gives 5 for read, 7 for write and read-modify-write, and 1 for execute. Any other code gives 13 for read, 15 for write and read-modify-write, and 12 for execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 read-modify-write, 3 execute |
| priv_user_i | input | 1 | 1 for user privilege, 0 for supervisor |
| exec_readable_i | input | 1 | Lets executable pages satisfy reads |
| sup_user_ok_i | input | 1 | Lets supervisor data accesses reach user pages |
| attr_i | input | 8 | Entry attribute byte: D A G U X W R V from bit 7 to bit 0 |
| fail_code_i | input | 3 | Internal failure code to translate into a cause |
| permit_o | output | 1 | Access is allowed by the attribute byte |
| upd_need_o | output | 1 | Accessed and/or dirty bit must be set |
| attr_new_o | output | 8 | Attribute byte with the required bits set |
| invalid_o | output | 1 | Byte encodes an invalid entry |
| pointer_o | output | 1 | Byte points to the next table level |
| cause_o | output | CAUSE_W | Architectural exception cause number |

## Verification
The checker assumes every input is a known 0 or 1 whenever it is evaluated. It also assumes `cause_o` only matters for the five defined failure codes, although the mapping is total. The bench drives all inputs from time zero, changes them only on the falling clock edge, and samples a quarter period later. It covers every attribute byte under each access kind, privilege and flag combination, and only the five defined failure codes.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FL_MEMERR   = 3'd0,
        FL_BADENT   = 3'd1,
        FL_NOPERM   = 3'd2,
        FL_MISALIGN = 3'd3,
        FL_UPDOFF   = 3'd4
    } fail_code_e;

    // attribute byte bit positions (decoded by neighbouring logic)
    localparam int ATTR_W = 8;
    localparam int B_VLD  = 0;
    localparam int B_RD   = 1;
    localparam int B_WR   = 2;
    localparam int B_EX   = 3;
    localparam int B_USR  = 4;
    localparam int B_GLB  = 5;
    localparam int B_ACC  = 6;
    localparam int B_DRT  = 7;

    // architectural cause numbers
    localparam int CS_FETCH_ACC = 1;
    localparam int CS_LOAD_ACC  = 5;
    localparam int CS_STORE_ACC = 7;
    localparam int CS_FETCH_PG  = 12;
    localparam int CS_LOAD_PG   = 13;
    localparam int CS_STORE_PG  = 15;

endpackage

// File: rtl/pgperm_classify.sv
module pgperm_classify
    import pgperm_pkg::*;
(
    input  logic [B_EX:B_VLD] low_i,
    output logic              invalid_o,
    output logic              pointer_o
);
    logic vld, rd, wr, ex;

    always_comb begin
        vld = low_i[B_VLD];
        rd  = low_i[B_RD];
        wr  = low_i[B_WR];
        ex  = low_i[B_EX];
        invalid_o = !vld || (wr && !rd);
        pointer_o = !(rd || wr || ex);
    end
endmodule

// File: rtl/pgperm_access.sv
module pgperm_access
    import pgperm_pkg::*;
(
    input  acc_kind_e          kind_i,
    input  logic               user_i,
    input  logic               exec_readable_i,
    input  logic               sup_user_ok_i,
    input  logic [B_USR:B_RD]  perm_i,
    output logic               permit_o
);
    logic rd_ok, wr_ok, ex_ok, usr_pg;
    logic data_ok;

    always_comb begin
        usr_pg = perm_i[B_USR];
        wr_ok  = perm_i[B_WR];
        ex_ok  = perm_i[B_EX];
        rd_ok  = perm_i[B_RD] || (perm_i[B_EX] && exec_readable_i);

        unique case (kind_i)
            ACC_READ:  data_ok = rd_ok;
            ACC_WRITE: data_ok = wr_ok;
            ACC_RMW:   data_ok = wr_ok && rd_ok;
            ACC_EXEC:  data_ok = ex_ok;
        endcase

        if (user_i) begin
            permit_o = usr_pg && data_ok;
        end else if (kind_i == ACC_EXEC) begin
            permit_o = !usr_pg && ex_ok;
        end else begin
            permit_o = (!usr_pg || sup_user_ok_i) && data_ok;
        end
    end
endmodule

// File: rtl/pgperm_adupd.sv
module pgperm_adupd
    import pgperm_pkg::*;
(
    input  acc_kind_e          kind_i,
    input  logic [ATTR_W-1:0]  attr_i,
    output logic               upd_need_o,
    output logic [ATTR_W-1:0]  attr_new_o
);
    logic is_store, need_a, need_d;

    always_comb begin
        unique case (kind_i)
            ACC_WRITE, ACC_RMW: is_store = 1'b1;
            ACC_READ,  ACC_EXEC: is_store = 1'b0;
        endcase
        need_a = !attr_i[B_ACC];
        need_d = is_store && !attr_i[B_DRT];
        upd_need_o = need_a || need_d;
        attr_new_o = attr_i;
        if (upd_need_o) begin
            attr_new_o[B_ACC] = 1'b1;
        end
        if (need_d) begin
            attr_new_o[B_DRT] = 1'b1;
        end
    end
endmodule

// File: rtl/pgperm_cause.sv
module pgperm_cause
    import pgperm_pkg::*;
#(
    parameter int CAUSE_W = 5
) (
    input  acc_kind_e           kind_i,
    input  logic [2:0]          fail_i,
    output logic [CAUSE_W-1:0]  cause_o
);
    logic is_mem;

    always_comb begin
        is_mem = (fail_i == FL_MEMERR);
        unique case (kind_i)
            ACC_READ:
                cause_o = is_mem ? CAUSE_W'(CS_LOAD_ACC)  : CAUSE_W'(CS_LOAD_PG);
            ACC_WRITE, ACC_RMW:
                cause_o = is_mem ? CAUSE_W'(CS_STORE_ACC) : CAUSE_W'(CS_STORE_PG);
            ACC_EXEC:
                cause_o = is_mem ? CAUSE_W'(CS_FETCH_ACC) : CAUSE_W'(CS_FETCH_PG);
        endcase
    end
endmodule

// File: rtl/pgperm_top.sv
module pgperm_top
    import pgperm_pkg::*;
#(
    parameter int CAUSE_W = 5
) (
    input  logic [1:0]          acc_kind_i,
    input  logic                priv_user_i,
    input  logic                exec_readable_i,
    input  logic                sup_user_ok_i,
    input  logic [7:0]          attr_i,
    input  logic [2:0]          fail_code_i,
    output logic                permit_o,
    output logic                upd_need_o,
    output logic [7:0]          attr_new_o,
    output logic                invalid_o,
    output logic                pointer_o,
    output logic [CAUSE_W-1:0]  cause_o
);
    acc_kind_e kind;
    assign kind = acc_kind_e'(acc_kind_i);

    pgperm_classify u_classify (
        .low_i     (attr_i[B_EX:B_VLD]),
        .invalid_o (invalid_o),
        .pointer_o (pointer_o)
    );

    pgperm_access u_access (
        .kind_i          (kind),
        .user_i          (priv_user_i),
        .exec_readable_i (exec_readable_i),
        .sup_user_ok_i   (sup_user_ok_i),
        .perm_i          (attr_i[B_USR:B_RD]),
        .permit_o        (permit_o)
    );

    pgperm_adupd u_adupd (
        .kind_i     (kind),
        .attr_i     (attr_i),
        .upd_need_o (upd_need_o),
        .attr_new_o (attr_new_o)
    );

    pgperm_cause #(.CAUSE_W(CAUSE_W)) u_cause (
        .kind_i  (kind),
        .fail_i  (fail_code_i),
        .cause_o (cause_o)
    );
endmodule

// File: rtl/pgperm_chk.sv
module pgperm_chk #(
    parameter int CAUSE_W = 5
) (
    input logic [1:0]          acc_kind_i,
    input logic                priv_user_i,
    input logic                exec_readable_i,
    input logic [7:0]          attr_i,
    input logic                permit_o,
    input logic                upd_need_o,
    input logic [7:0]          attr_new_o,
    input logic                pointer_o,
    input logic [CAUSE_W-1:0]  cause_o
);
    always_comb begin
        AST_PTR_NEVER_PERMIT: assert (!(pointer_o && permit_o))
            else $error("pointer byte permitted"); // R2
        AST_WRITE_NEEDS_W: assert (!(acc_kind_i == 2'd1 && !attr_i[2] && permit_o))
            else $error("write permitted without W"); // R3
        AST_SUP_EXEC_USER_PG: assert (!(!priv_user_i && acc_kind_i == 2'd3 && attr_i[4] && permit_o))
            else $error("supervisor fetch from user page"); // R5
        AST_MXR_NO_EXEC_GAIN: assert (!(acc_kind_i == 2'd3 && !attr_i[3] && permit_o))
            else $error("execute permitted without X"); // R6
        AST_NO_UPD_UNCHANGED: assert (upd_need_o || attr_new_o == attr_i)
            else $error("byte changed without update"); // R7
        AST_UPD_ONLY_SETS: assert ((attr_new_o & attr_i) == attr_i)
            else $error("update cleared a bit"); // R8
        AST_LOW_BITS_KEPT: assert (attr_new_o[5:0] == attr_i[5:0])
            else $error("low attribute bits altered"); // R8
        AST_CAUSE_LEGAL: assert (cause_o == CAUSE_W'(1) || cause_o == CAUSE_W'(5) ||
                                 cause_o == CAUSE_W'(7) || cause_o == CAUSE_W'(12) ||
                                 cause_o == CAUSE_W'(13) || cause_o == CAUSE_W'(15))
            else $error("illegal cause"); // R9
        AST_EXR_NO_WRITE_GAIN: assert (!(exec_readable_i && acc_kind_i == 2'd1 && !attr_i[2] && permit_o))
            else $error("exec-readable granted write"); // R6
    end
endmodule

bind pgperm_top pgperm_chk #(.CAUSE_W(CAUSE_W)) u_chk (
    .acc_kind_i      (acc_kind_i),
    .priv_user_i     (priv_user_i),
    .exec_readable_i (exec_readable_i),
    .attr_i          (attr_i),
    .permit_o        (permit_o),
    .upd_need_o      (upd_need_o),
    .attr_new_o      (attr_new_o),
    .pointer_o       (pointer_o),
    .cause_o         (cause_o)
);

// File: tb/sim_pgperm_top.sv
module sim_pgperm_top;
    localparam int CLK_PERIOD = 10;
    localparam int CAUSE_W    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]         acc_kind_i = '0;
    logic               priv_user_i = 1'b0;
    logic               exec_readable_i = 1'b0;
    logic               sup_user_ok_i = 1'b0;
    logic [7:0]         attr_i = '0;
    logic [2:0]         fail_code_i = '0;
    logic               permit_o, upd_need_o, invalid_o, pointer_o;
    logic [7:0]         attr_new_o;
    logic [CAUSE_W-1:0] cause_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    pgperm_top #(.CAUSE_W(CAUSE_W)) u0 (
        .acc_kind_i      (acc_kind_i),
        .priv_user_i     (priv_user_i),
        .exec_readable_i (exec_readable_i),
        .sup_user_ok_i   (sup_user_ok_i),
        .attr_i          (attr_i),
        .fail_code_i     (fail_code_i),
        .permit_o        (permit_o),
        .upd_need_o      (upd_need_o),
        .attr_new_o      (attr_new_o),
        .invalid_o       (invalid_o),
        .pointer_o       (pointer_o),
        .cause_o         (cause_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (kind=%0d user=%0d exr=%0d sum=%0d attr=%02h fail=%0d)",
                     req, act, exp, acc_kind_i, priv_user_i, exec_readable_i,
                     sup_user_ok_i, attr_i, fail_code_i);
        end
    endtask

    task automatic drive(input int kind, input bit user, input bit exr,
                         input bit sum, input int attr, input int fl);
        @(negedge clk);
        acc_kind_i      = 2'(kind);
        priv_user_i     = user;
        exec_readable_i = exr;
        sup_user_ok_i   = sum;
        attr_i          = 8'(attr);
        fail_code_i     = 3'(fl);
        #(CLK_PERIOD/4);
    endtask

    function automatic bit ref_permit(int kind, bit user, bit exr, bit sum, logic [7:0] a);
        bit rd, wr, ex, us, d;
        rd = a[1] | (a[3] & exr);
        wr = a[2];
        ex = a[3];
        us = a[4];
        case (kind)
            0: d = rd;
            1: d = wr;
            2: d = wr & rd;
            default: d = ex;
        endcase
        if (user) return us & d;
        if (kind == 3) return !us & ex;
        return (!us | sum) & d;
    endfunction

    task automatic test_idle();
        drive(0, 0, 0, 0, 8'h00, 0);
        chk("R1 idle invalid", invalid_o, 1);
        chk("R2 idle pointer", pointer_o, 1);
        chk("R2 idle permit", permit_o, 0);
        chk("R7 idle upd", upd_need_o, 1);
        chk("R7 idle new", attr_new_o, 8'h40);
        chk("R9 idle cause", cause_o, 5);
    endtask

    task automatic test_classify();
        drive(0, 1, 0, 0, 8'h01, 1);
        chk("R1 v-only valid", invalid_o, 0);  chk("R2 v-only ptr", pointer_o, 1);
        drive(0, 1, 0, 0, 8'h05, 1);
        chk("R1 W without R", invalid_o, 1);   chk("R2 W without R", pointer_o, 0);
        drive(0, 1, 0, 0, 8'h07, 1);
        chk("R1 RW valid", invalid_o, 0);      chk("R2 RW leaf", pointer_o, 0);
        drive(0, 1, 0, 0, 8'h09, 1);
        chk("R1 X valid", invalid_o, 0);       chk("R2 X leaf", pointer_o, 0);
        drive(0, 1, 0, 0, 8'h0E, 1);
        chk("R1 no V", invalid_o, 1);
    endtask

    task automatic test_user();
        drive(0, 1, 0, 0, 8'h13, 0); chk("R3 user read U R", permit_o, 1);
        drive(1, 1, 0, 0, 8'h13, 0); chk("R3 user write no W", permit_o, 0);
        drive(2, 1, 0, 0, 8'h17, 0); chk("R3 user rmw RW", permit_o, 1);
        drive(2, 1, 0, 0, 8'h15, 0); chk("R3 user rmw no R", permit_o, 0);
        drive(0, 1, 0, 1, 8'h03, 0); chk("R3 user read no U", permit_o, 0);
        drive(3, 1, 0, 0, 8'h19, 0); chk("R3 user exec", permit_o, 1);
    endtask

    task automatic test_super();
        drive(0, 0, 0, 0, 8'h13, 0); chk("R4 sup read U page no sum", permit_o, 0);
        drive(0, 0, 0, 1, 8'h13, 0); chk("R4 sup read U page sum", permit_o, 1);
        drive(0, 0, 0, 0, 8'h03, 0); chk("R4 sup read S page", permit_o, 1);
        drive(1, 0, 0, 1, 8'h17, 0); chk("R4 sup write U page sum", permit_o, 1);
        drive(3, 0, 0, 1, 8'h19, 0); chk("R5 sup exec U page sum", permit_o, 0);
        drive(3, 0, 0, 0, 8'h09, 0); chk("R5 sup exec S page", permit_o, 1);
        drive(3, 0, 0, 0, 8'h03, 0); chk("R5 sup exec no X", permit_o, 0);
    endtask

    task automatic test_exec_readable();
        drive(0, 1, 0, 0, 8'h19, 0); chk("R6 read X no flag", permit_o, 0);
        drive(0, 1, 1, 0, 8'h19, 0); chk("R6 read X flag", permit_o, 1);
        drive(0, 0, 1, 0, 8'h09, 0); chk("R6 sup read X flag", permit_o, 1);
        drive(1, 1, 1, 0, 8'h19, 0); chk("R6 write X flag", permit_o, 0);
        drive(2, 1, 1, 0, 8'h1D, 0); chk("R6 rmw WX flag", permit_o, 1);
        drive(3, 1, 1, 0, 8'h13, 0); chk("R6 exec R flag", permit_o, 0);
    endtask

    task automatic test_update();
        drive(0, 1, 0, 0, 8'h07, 0); chk("R7 read A clear upd", upd_need_o, 1);
        chk("R7 read A clear new", attr_new_o, 8'h47);
        drive(0, 1, 0, 0, 8'h47, 0); chk("R7 read A set upd", upd_need_o, 0);
        chk("R7 read A set new", attr_new_o, 8'h47);
        drive(1, 1, 0, 0, 8'h47, 0); chk("R7 write D clear upd", upd_need_o, 1);
        chk("R7 write D clear new", attr_new_o, 8'hC7);
        drive(2, 1, 0, 0, 8'h47, 0); chk("R7 rmw D clear new", attr_new_o, 8'hC7);
        drive(3, 1, 0, 0, 8'h47, 0); chk("R7 exec A set upd", upd_need_o, 0);
        drive(1, 1, 0, 0, 8'h07, 0); chk("R7 write both new", attr_new_o, 8'hC7);
        drive(1, 1, 0, 0, 8'hC7, 0); chk("R7 write both set upd", upd_need_o, 0);
        drive(3, 1, 0, 0, 8'h3F, 0); chk("R8 exec keeps G U", attr_new_o, 8'h7F);
        drive(1, 1, 0, 0, 8'h2A, 0); chk("R8 write keeps low", attr_new_o, 8'hEA);
    endtask

    task automatic test_cause();
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 5; f++) begin
                int exp;
                drive(k, 0, 0, 0, 8'h00, f);
                if (k == 0)      exp = (f == 0) ? 5 : 13;
                else if (k == 3) exp = (f == 0) ? 1 : 12;
                else             exp = (f == 0) ? 7 : 15;
                chk("R9 cause map", cause_o, exp);
            end
        end
    endtask

    task automatic test_sweep();
        for (int a = 0; a < 256; a++) begin
            for (int m = 0; m < 32; m++) begin
                drive(m & 3, m[2], m[3], m[4], a, 1);
                chk("R3 R4 R5 R6 sweep permit", permit_o,
                    ref_permit(m & 3, m[2], m[3], m[4], 8'(a)));
            end
            chk("R1 sweep invalid", invalid_o, int'(!a[0] || (a[2] && !a[1])));
            chk("R2 sweep pointer", pointer_o, int'(a[3:1] == 3'b000));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_idle();
        test_classify();
        test_user();
        test_super();
        test_exec_readable();
        test_update();
        test_cause();
        test_sweep();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule